// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port memory and decides, one clock cycle at a time, which port may touch a shared location when both ports aim at it. Each port presents a chip enable, a write strobe, an address and a valid strobe. A port is requesting when both its enable and its valid are high. Two requesting ports contend when their addresses are equal. The port that got to the location first keeps it, and the other port sees its busy flag raised until the clash ends.

A mode input picks one of two roles. As the master, the block drives its own busy decisions out, so that companion devices can use them. As a slave, it drives no busy and instead takes one busy input per port from an external master. In both roles each port gets a write-permit output. That output is high only when the port is requesting a write and is not under busy. The busy and write-permit outputs are combinational from the port inputs and the registered ownership state, so a decision applies in the same cycle as the request that caused it.

Top module: `contention_arbiter`

## Requirements
- R1: A busy output can be high only while both ports are requesting (enable and valid both 1) and their addresses are equal. In every other cycle both busy outputs are 0.
- R2: When contention begins and one port was already requesting that same address in the previous cycle while the other was not, the earlier port wins and busy goes to the other port in that same cycle. The winner keeps the location for as long as contention lasts.
- R3: Busy to the losing port drops in the same cycle that the addresses stop matching, or in the same cycle that the winning port stops requesting.
- R4: In master mode, during contention exactly one busy output is high. The two busy outputs are never high together.
- R5: When both ports start requesting the same address in the same cycle, the left port wins and the right port gets busy.
- R6: With master_mode at 1, the busy outputs carry the arbiter's decision. With master_mode at 0, both busy outputs stay at 0.
- R7: In slave mode, a port's write permit equals request AND wr AND NOT that port's busy input. The busy inputs have no effect in master mode.
- R8: In master mode, the write permit of the port that is receiving busy is 0, while the winning port's write permit follows its request and wr.
- R9: While rst_n is 0, all busy and write-permit outputs are 0. Reset clears ownership and request history, so two ports that are already contending when reset is released are treated as a same-cycle tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = master (busy driven), 0 = slave (busy taken in) |
| l_en | input | 1 | Left port chip enable |
| l_wr | input | 1 | Left port write (1) / read (0) |
| l_vld | input | 1 | Left port address valid strobe |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port chip enable |
| r_wr | input | 1 | Right port write (1) / read (0) |
| r_vld | input | 1 | Right port address valid strobe |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in | input | 1 | External busy for the left port (slave mode) |
| r_busy_in | input | 1 | External busy for the right port (slave mode) |
| l_busy | output | 1 | Busy to the left port (master mode) |
| r_busy | output | 1 | Busy to the right port (master mode) |
| l_wr_ok | output | 1 | Left port write permitted |
| r_wr_ok | output | 1 | Right port write permitted |

## Verification
The hardest case to reach is the arrival-order decision. It needs one port to hold an address for at least a cycle before the other port moves onto that same address, and then the clash must end through each of the two release paths. Random stimulus rarely builds this, even with a narrow address range. So directed sequences set up left-first, right-first and same-cycle arrivals, and then end each clash once by an address change and once by the winner dropping its enable. A reset applied in the middle of a clash checks that the arrival history is cleared. Random cycles then mix the mode, the strobes and the external busy inputs over four addresses, so that clashes are frequent.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
    } arb_state_t;
endpackage

// File: rtl/port_track.sv
module port_track #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              vld,
    input  logic [ADDR_W-1:0] addr,
    output logic              req,
    output logic              held
);
    typedef struct packed {
        logic              req;
        logic [ADDR_W-1:0] addr;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        req      = en & vld;
        held     = req & trk_q.req & (trk_q.addr == addr);
        trk_d    = trk_q;
        trk_d.req  = req;
        trk_d.addr = addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end
endmodule

// File: rtl/write_gate.sv
module write_gate (
    input  logic act,
    input  logic req,
    input  logic wr,
    input  logic busy,
    output logic wr_ok
);
    always_comb wr_ok = act & req & wr & ~busy;
endmodule

// File: rtl/contention_arbiter.sv
module contention_arbiter
    import arb_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic              l_vld,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic              r_vld,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in,
    input  logic              r_busy_in,
    output logic              l_busy,
    output logic              r_busy,
    output logic              l_wr_ok,
    output logic              r_wr_ok
);
    localparam int NPORT = 2;

    logic [NPORT-1:0] en_v, vld_v, wr_v, bin_v, req_v, held_v, busy_v, beff_v, wrok_v;
    logic [ADDR_W-1:0] addr_v [NPORT];
    logic match;

    arb_state_t st_d, st_q;

    assign en_v  = {r_en, l_en};
    assign vld_v = {r_vld, l_vld};
    assign wr_v  = {r_wr, l_wr};
    assign bin_v = {r_busy_in, l_busy_in};
    assign addr_v[0] = l_addr;
    assign addr_v[1] = r_addr;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_track #(.ADDR_W(ADDR_W)) u_trk (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[p]),
            .vld   (vld_v[p]),
            .addr  (addr_v[p]),
            .req   (req_v[p]),
            .held  (held_v[p])
        );

        assign beff_v[p] = master_mode ? busy_v[p] : bin_v[p];

        write_gate u_gate (
            .act   (rst_n),
            .req   (req_v[p]),
            .wr    (wr_v[p]),
            .busy  (beff_v[p]),
            .wr_ok (wrok_v[p])
        );
    end

    always_comb begin
        match = req_v[0] & req_v[1] & (addr_v[0] == addr_v[1]);
        st_d  = st_q;
        if (!match) begin
            st_d.owner = OWN_NONE;
        end else if (st_q.owner == OWN_NONE) begin
            // earlier arrival wins; a same-cycle arrival goes to the left port
            if (held_v[1] && !held_v[0]) st_d.owner = OWN_RIGHT;
            else                         st_d.owner = OWN_LEFT;
        end
        busy_v[0] = rst_n & master_mode & (st_d.owner == OWN_RIGHT);
        busy_v[1] = rst_n & master_mode & (st_d.owner == OWN_LEFT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{owner: OWN_NONE};
        else        st_q <= st_d;
    end

    assign l_busy  = busy_v[0];
    assign r_busy  = busy_v[1];
    assign l_wr_ok = wrok_v[0];
    assign r_wr_ok = wrok_v[1];
endmodule

// File: rtl/contention_arbiter_chk.sv
module contention_arbiter_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_mode,
    input logic              l_en,
    input logic              l_wr,
    input logic              l_vld,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_en,
    input logic              r_wr,
    input logic              r_vld,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_in,
    input logic              r_busy_in,
    input logic              l_busy,
    input logic              r_busy,
    input logic              l_wr_ok,
    input logic              r_wr_ok
);
    logic clash;
    assign clash = l_en & l_vld & r_en & r_vld & (l_addr == r_addr);

    AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_busy && r_busy)); // R4

    AST_ONE_BUSY_ON_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && clash) |-> ($countones({l_busy, r_busy}) == 1)); // R4

    AST_NO_BUSY_WITHOUT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !clash |-> (!l_busy && !r_busy)); // R1

    AST_SLAVE_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (!l_busy && !r_busy)); // R6

    AST_SLAVE_GATE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && l_busy_in) |-> !l_wr_ok); // R7

    AST_SLAVE_GATE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && r_busy_in) |-> !r_wr_ok); // R7

    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        master_mode |-> !(l_busy && l_wr_ok) && !(r_busy && r_wr_ok)); // R8

    AST_WINNER_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && clash && $past(master_mode) && $past(clash) && $past(r_busy))
        |-> r_busy); // R2

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!l_busy && !r_busy && !l_wr_ok && !r_wr_ok); // R9
        end
    end
endmodule

bind contention_arbiter contention_arbiter_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_wr(l_wr), .l_vld(l_vld), .l_addr(l_addr),
    .r_en(r_en), .r_wr(r_wr), .r_vld(r_vld), .r_addr(r_addr),
    .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
    .l_busy(l_busy), .r_busy(r_busy), .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
);

// File: tb/contention_arbiter_tb_top.sv
`timescale 1ns/1ps
module contention_arbiter_tb_top;
    localparam int AW = 14;

    logic clk = 1'b0;
    logic rst_n, mm, le, lw, lv, re, rw, rv, bl, br;
    logic [AW-1:0] la, ra;
    logic l_busy, r_busy, l_wr_ok, r_wr_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    int   m_owner = 0;          // 0 none, 1 left, 2 right
    bit   m_preq_l = 0, m_preq_r = 0;
    logic [AW-1:0] m_pa_l = '0, m_pa_r = '0;

    always #2.5 clk = ~clk;

    contention_arbiter #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_mode(mm),
        .l_en(le), .l_wr(lw), .l_vld(lv), .l_addr(la),
        .r_en(re), .r_wr(rw), .r_vld(rv), .r_addr(ra),
        .l_busy_in(bl), .r_busy_in(br),
        .l_busy(l_busy), .r_busy(r_busy), .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
    );

    function automatic int next_owner();
        bit ql, qr, hl, hr, m;
        ql = le & lv;
        qr = re & rv;
        m  = ql & qr & (la == ra);
        hl = ql & m_preq_l & (m_pa_l == la);
        hr = qr & m_preq_r & (m_pa_r == ra);
        if (!m) return 0;
        if (m_owner != 0) return m_owner;
        if (hr && !hl) return 2;
        return 1;
    endfunction

    task automatic cmp(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag);
        int  own;
        bit  ebl, ebr, effl, effr, ewl, ewr;
        #1;
        own  = next_owner();
        ebl  = rst_n & mm & (own == 2);
        ebr  = rst_n & mm & (own == 1);
        effl = mm ? ebl : bl;
        effr = mm ? ebr : br;
        ewl  = rst_n & le & lv & lw & !effl;
        ewr  = rst_n & re & rv & rw & !effr;
        cmp(tag, "l_busy",  l_busy,  ebl);
        cmp(tag, "r_busy",  r_busy,  ebr);
        cmp(tag, "l_wr_ok", l_wr_ok, ewl);
        cmp(tag, "r_wr_ok", r_wr_ok, ewr);
        @(posedge clk);
        if (!rst_n) begin
            m_owner = 0; m_preq_l = 0; m_preq_r = 0; m_pa_l = '0; m_pa_r = '0;
        end else begin
            m_owner = own;
            m_preq_l = le & lv; m_preq_r = re & rv;
            m_pa_l = la; m_pa_r = ra;
        end
        @(negedge clk);
    endtask

    task automatic drive(input bit m, input bit e0, input bit w0, input bit v0, input int a0,
                         input bit e1, input bit w1, input bit v1, input int a1,
                         input bit b0, input bit b1);
        mm = m; le = e0; lw = w0; lv = v0; la = AW'(a0);
        re = e1; rw = w1; rv = v1; ra = AW'(a1);
        bl = b0; br = b1;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        drive(1, 1,1,1,5, 1,1,1,5, 0,0);
        @(negedge clk);
        step("R9 reset");
        step("R9 reset");
        rst_n = 1;
        // contending at release: tie, left wins
        step("R9 tie after reset");
        step("R2 left holds");
        // left first, right joins
        drive(1, 1,1,1,7, 0,0,0,7, 0,0); step("R1 left alone");
        drive(1, 1,1,1,7, 1,1,1,7, 0,0); step("R2 left first");
        step("R8 loser write blocked");
        drive(1, 1,1,1,8, 1,1,1,7, 0,0); step("R3 address change release");
        // right first, left joins
        drive(1, 0,0,0,9, 1,1,1,9, 0,0); step("R1 right alone");
        drive(1, 1,1,1,9, 1,1,1,9, 1,1); step("R2 right first");
        step("R7 busy_in ignored in master");
        drive(1, 1,1,1,9, 0,1,1,9, 0,0); step("R3 winner enable drop");
        // same-cycle tie from idle
        drive(1, 0,0,0,0, 0,0,0,0, 0,0); step("R1 idle");
        drive(1, 1,0,1,3, 1,1,1,3, 0,0); step("R5 same cycle tie");
        drive(1, 1,0,0,3, 1,1,1,3, 0,0); step("R3 winner valid drop");
        // different addresses
        drive(1, 1,1,1,4, 1,1,1,6, 0,0); step("R1 distinct addresses");
        // slave mode
        drive(0, 1,1,1,2, 1,1,1,2, 1,0); step("R7 slave left gated");
        drive(0, 1,1,1,2, 1,1,1,2, 0,1); step("R6 slave no busy out");
        drive(0, 1,1,1,2, 1,1,1,5, 0,0); step("R7 slave both free");
        // reset mid contention
        drive(1, 0,0,0,1, 1,1,1,1, 0,0); step("R1 right alone");
        drive(1, 1,1,1,1, 1,1,1,1, 0,0); step("R2 right first again");
        rst_n = 0; step("R9 reset mid clash");
        rst_n = 1; step("R9 history cleared tie");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            rst_n = ($urandom_range(0, 199) != 0);
            drive($urandom_range(0, 3) != 0,
                  $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 4) != 0,
                  $urandom_range(0, 3),
                  $urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 4) != 0,
                  $urandom_range(0, 3),
                  $urandom_range(0, 1), $urandom_range(0, 1));
            step("R4 random");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
    end
endmodule